// File: doc/BRIEF.md
# Programmable Bank Window Address Mapper

This block sits between a CPU with a 16-bit address bus and a 512 KB static RAM that needs 19 address bits. It opens one window in the CPU address space. The window's size can be any power of two from 2 KB to 32 KB, and its position is programmable. CPU accesses that fall inside the window are steered to a RAM block chosen by a swap register. All other accesses reach the bottom 64 KB of RAM unchanged.

Two 5-bit registers set the window: a bank mask and a bank base. Both are written over a small host register port. The 8-bit swap register names a 2 KB block of RAM. It is loaded when the CPU performs an I/O write carrying a block number. On that load, the hardware adds a fixed offset to the value, so banked accesses can never reach the low 64 KB that unbanked accesses use.

The address path is purely combinational: a masked XOR compare on CPU A15..A11 followed by a row of 2:1 selects. Register writes take effect from the clock edge on which they occur.

Top module: `bank_window_mapper`

## Requirements
- R1: After reset the mask is 0x10 and the base is 0x10, so the window covers CPU 0x8000..0xFFFF. The swap register holds the offset value 0x20 and `swap_ovf` is 0. CPU address 0x8000 therefore maps to 0x10000, and CPU address 0x0000 maps to 0x00000.
- R2: RAM address bits 10..0 always equal CPU address bits 10..0.
- R3: `banked` is 1 exactly when, for every bit position i in 0..4 where mask bit i is 1, CPU address bit 11+i equals base bit i.
- R4: When `banked` is 0, `sram_addr` equals the CPU address with bits 18..16 set to 0.
- R5: When `banked` is 1, RAM bits 18..16 come from swap bits 7..5. Each RAM bit 11+i (i in 0..4) takes swap bit i when mask bit i is 1, and CPU bit 11+i when mask bit i is 0.
- R6: A CPU I/O write of value v with v+32 <= 255 loads the swap register with v+32 and clears `swap_ovf`. The new value is used from the next clock edge. With no I/O write, the swap register holds its value.
- R7: A CPU I/O write with v+32 > 255 sets the swap register to 0xFF and sets `swap_ovf` to 1. A later write that does not overflow clears `swap_ovf`.
- R8: A host write with `host_sel`=0 loads the mask from `host_wdata[4:0]`, and one with `host_sel`=1 loads the base from the same bits. Bits 7..5 of the write data are ignored.
- R9: A mask value other than the five size encodings is applied bit by bit. A mask of 0x00 places every CPU address in the window.
- R10: The mask encodings 0x10, 0x18, 0x1C, 0x1E and 0x1F give windows of 32 KB, 16 KB, 8 KB, 4 KB and 2 KB. In general the window spans 2 KB times 2^(5 - number of ones in the mask).
- R11: Whenever `banked` is 1, the RAM address is at or above 0x10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 1 | Register select: 0 = mask, 1 = base |
| host_wdata | input | 8 | Host write data (bits 4..0 used) |
| cpu_io_wr | input | 1 | CPU I/O write strobe to the swap register |
| cpu_io_data | input | 8 | Block number written by the CPU |
| cpu_addr | input | 16 | CPU address |
| sram_addr | output | 19 | Translated RAM address |
| banked | output | 1 | CPU address lies inside the window |
| swap_ovf | output | 1 | Last swap load exceeded RAM and was saturated |

## Verification
Every cycle, the assertions check the following:
- the low page bits always pass through;
- addresses outside the window pass through with zero upper bits;
- banked accesses never fall below 64 KB;
- the swap register's load, saturate and hold behaviour;
- the host register loads;
- the all-ones window that an empty mask gives.

The correct choice between swap bits and CPU bits in the middle field, and the window size that each mask encoding yields, are only shown by the bench. It sweeps all five sizes over many base values and random addresses and compares the results against a reference model.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
   typedef enum logic {
      SEL_MASK = 1'b0,
      SEL_BASE = 1'b1
   } host_sel_e;

   localparam logic [4:0] WIN_32K = 5'h10;
   localparam logic [4:0] WIN_16K = 5'h18;
   localparam logic [4:0] WIN_8K  = 5'h1C;
   localparam logic [4:0] WIN_4K  = 5'h1E;
   localparam logic [4:0] WIN_2K  = 5'h1F;
endpackage

// File: rtl/bwm_window_regs.sv
module bwm_window_regs
   import bwm_pkg::*;
#(
   parameter int CMP_W    = 5,
   parameter int HOST_DW  = 8,
   parameter int RST_MASK = 'h10,
   parameter int RST_BASE = 'h10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic               host_sel,
   input  logic [HOST_DW-1:0] host_wdata,
   output logic [CMP_W-1:0]   mask,
   output logic [CMP_W-1:0]   base
);
   generate
      if (HOST_DW < CMP_W) begin : g_bad_dw
         $error("host data narrower than window field");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= CMP_W'(RST_MASK);
         base <= CMP_W'(RST_BASE);
      end else if (host_wr) begin
         if (host_sel == SEL_MASK) mask <= host_wdata[CMP_W-1:0];
         else                      base <= host_wdata[CMP_W-1:0];
      end
   end

   // R8
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_sel == 1'b0 |=> mask == $past(host_wdata[CMP_W-1:0]));
   // R8
   base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_sel == 1'b1 |=> base == $past(host_wdata[CMP_W-1:0]));
endmodule

// File: rtl/bwm_swap_loader.sv
module bwm_swap_loader #(
   parameter int SWAP_W   = 8,
   parameter int OFFSET   = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [SWAP_W-1:0] io_data,
   output logic [SWAP_W-1:0] swap,
   output logic              ovf
);
   localparam int MAXV  = (1 << SWAP_W) - 1;
   localparam int LIMIT = MAXV - OFFSET;

   generate
      if (OFFSET < 0 || OFFSET > MAXV) begin : g_bad_off
         $error("offset outside swap range");
      end
   endgenerate

   logic [SWAP_W:0]   sum;
   logic              over;
   logic [SWAP_W-1:0] nxt;

   assign sum  = {1'b0, io_data} + (SWAP_W+1)'(OFFSET);
   assign over = sum[SWAP_W];

   generate
      if (SATURATE) begin : g_sat
         assign nxt = over ? {SWAP_W{1'b1}} : sum[SWAP_W-1:0];
      end else begin : g_reject
         assign nxt = over ? swap : sum[SWAP_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         swap <= SWAP_W'(OFFSET);
         ovf  <= 1'b0;
      end else if (io_wr) begin
         swap <= nxt;
         ovf  <= over;
      end
   end

   // R6
   load_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr && int'(io_data) <= LIMIT |=> !ovf && int'(swap) == int'($past(io_data)) + OFFSET);
   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr |=> $stable(swap) && $stable(ovf));
   // R7
   over_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr && int'(io_data) > LIMIT |=> ovf);
   generate
      if (SATURATE) begin : g_sat_chk
         // R7
         saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            io_wr && int'(io_data) > LIMIT |=> swap == {SWAP_W{1'b1}});
      end
   endgenerate
endmodule

// File: rtl/bwm_window_match.sv
module bwm_window_match #(
   parameter int CMP_W = 5
) (
   input  logic [CMP_W-1:0] addr_hi,
   input  logic [CMP_W-1:0] base,
   input  logic [CMP_W-1:0] mask,
   output logic             hit
);
   logic [CMP_W-1:0] miss;

   generate
      for (genvar i = 0; i < CMP_W; i++) begin : g_bit
         assign miss[i] = (addr_hi[i] ^ base[i]) & mask[i];
      end
   endgenerate

   assign hit = ~|miss;

   // R9
   always_comb begin
      if (mask == '0) begin
         empty_mask_hit_chk: assert (hit);
      end
   end
endmodule

// File: rtl/bwm_addr_mux.sv
module bwm_addr_mux #(
   parameter int CPU_AW    = 16,
   parameter int SRAM_AW   = 19,
   parameter int PAGE_BITS = 11
) (
   input  logic [CPU_AW-1:0]            cpu_addr,
   input  logic [SRAM_AW-PAGE_BITS-1:0] swap,
   input  logic [CPU_AW-PAGE_BITS-1:0]  mask,
   input  logic                         hit,
   output logic [SRAM_AW-1:0]           sram_addr
);
   localparam int CMP_W = CPU_AW - PAGE_BITS;
   localparam int HI_W  = SRAM_AW - CPU_AW;

   assign sram_addr[PAGE_BITS-1:0] = cpu_addr[PAGE_BITS-1:0];

   generate
      for (genvar i = 0; i < CMP_W; i++) begin : g_mid
         assign sram_addr[PAGE_BITS+i] = (hit && mask[i]) ? swap[i]
                                                          : cpu_addr[PAGE_BITS+i];
      end
      if (HI_W > 0) begin : g_hi
         assign sram_addr[SRAM_AW-1:CPU_AW] = hit ? swap[CMP_W +: HI_W] : '0;
      end
   endgenerate
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper #(
   parameter int CPU_AW        = 16,
   parameter int SRAM_AW       = 19,
   parameter int PAGE_BITS     = 11,
   parameter int HOST_DW       = 8,
   parameter int OFFSET_BLOCKS = 32,
   parameter bit SATURATE      = 1'b1,
   parameter int RST_MASK      = 'h10,
   parameter int RST_BASE      = 'h10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         host_wr,
   input  logic                         host_sel,
   input  logic [HOST_DW-1:0]           host_wdata,
   input  logic                         cpu_io_wr,
   input  logic [SRAM_AW-PAGE_BITS-1:0] cpu_io_data,
   input  logic [CPU_AW-1:0]            cpu_addr,
   output logic [SRAM_AW-1:0]           sram_addr,
   output logic                         banked,
   output logic                         swap_ovf
);
   localparam int CMP_W  = CPU_AW - PAGE_BITS;
   localparam int SWAP_W = SRAM_AW - PAGE_BITS;
   localparam bit GUARDS_LOW = (OFFSET_BLOCKS * (1 << PAGE_BITS)) >= (1 << CPU_AW);

   generate
      if (SRAM_AW < CPU_AW || PAGE_BITS >= CPU_AW) begin : g_bad_geom
         $error("inconsistent address widths");
      end
   endgenerate

   logic [CMP_W-1:0]  mask, base;
   logic [SWAP_W-1:0] swap;

   bwm_window_regs #(
      .CMP_W(CMP_W), .HOST_DW(HOST_DW), .RST_MASK(RST_MASK), .RST_BASE(RST_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
      .host_wdata(host_wdata), .mask(mask), .base(base)
   );

   bwm_swap_loader #(
      .SWAP_W(SWAP_W), .OFFSET(OFFSET_BLOCKS), .SATURATE(SATURATE)
   ) u_swap (
      .clk(clk), .rst_n(rst_n), .io_wr(cpu_io_wr), .io_data(cpu_io_data),
      .swap(swap), .ovf(swap_ovf)
   );

   bwm_window_match #(.CMP_W(CMP_W)) u_match (
      .addr_hi(cpu_addr[CPU_AW-1:PAGE_BITS]), .base(base), .mask(mask), .hit(banked)
   );

   bwm_addr_mux #(
      .CPU_AW(CPU_AW), .SRAM_AW(SRAM_AW), .PAGE_BITS(PAGE_BITS)
   ) u_mux (
      .cpu_addr(cpu_addr), .swap(swap), .mask(mask), .hit(banked), .sram_addr(sram_addr)
   );

   // R2
   page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sram_addr[PAGE_BITS-1:0] == cpu_addr[PAGE_BITS-1:0]);
   // R4
   passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !banked |-> sram_addr == SRAM_AW'(cpu_addr));
   generate
      if (GUARDS_LOW && SRAM_AW > CPU_AW) begin : g_low_chk
         // R11
         low_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
            banked |-> sram_addr[SRAM_AW-1:CPU_AW] != '0);
      end
   endgenerate
endmodule

// File: tb/tb_bank_window_mapper.sv
module tb_bank_window_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_sel = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic        cpu_io_wr = 1'b0;
   logic [7:0]  cpu_io_data = '0;
   logic [15:0] cpu_addr = '0;
   logic [18:0] sram_addr;
   logic        banked;
   logic        swap_ovf;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [4:0] m_mask, m_base;
   logic [7:0] m_swap;
   logic       m_ovf;

   always #5 clk = ~clk;

   bank_window_mapper dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
      .host_wdata(host_wdata), .cpu_io_wr(cpu_io_wr), .cpu_io_data(cpu_io_data),
      .cpu_addr(cpu_addr), .sram_addr(sram_addr), .banked(banked), .swap_ovf(swap_ovf)
   );

   function automatic logic in_win(input logic [15:0] a, input logic [4:0] m, input logic [4:0] b);
      for (int i = 0; i < 5; i++)
         if (m[i] && (a[11+i] != b[i])) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [18:0] ref_addr(input logic [15:0] a, input logic [4:0] m,
                                            input logic [4:0] b, input logic [7:0] s);
      logic [18:0] r;
      if (!in_win(a, m, b)) return {3'b000, a};
      r = {s[7:5], a};
      for (int i = 0; i < 5; i++)
         if (m[i]) r[11+i] = s[i];
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic host_write(input logic sel, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_sel = sel; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
      if (sel) m_base = d[4:0]; else m_mask = d[4:0];
   endtask

   task automatic cpu_load(input logic [7:0] v);
      @(negedge clk);
      cpu_io_wr = 1'b1; cpu_io_data = v;
      @(negedge clk);
      cpu_io_wr = 1'b0;
      if (int'(v) + 32 > 255) begin m_swap = 8'hFF; m_ovf = 1'b1; end
      else begin m_swap = v + 8'd32; m_ovf = 1'b0; end
   endtask

   task automatic probe(input string tag, input logic [15:0] a);
      cpu_addr = a;
      #1;
      check({tag, " addr"}, 32'(sram_addr), 32'(ref_addr(a, m_mask, m_base, m_swap)));
      check({tag, " banked"}, 32'(banked), 32'(in_win(a, m_mask, m_base)));
      if (banked) check("R11 above 64K", 32'(sram_addr >= 19'h10000), 32'd1);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [4:0] sizes [5];
      logic [7:0] sw;
      logic [4:0] bs;
      int cnt;
      void'($urandom(32'd1234));
      sizes[0] = 5'h10; sizes[1] = 5'h18; sizes[2] = 5'h1C; sizes[3] = 5'h1E; sizes[4] = 5'h1F;
      m_mask = 5'h10; m_base = 5'h10; m_swap = 8'h20; m_ovf = 1'b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cpu_addr = 16'h8000; #1;
      check("R1 reset banked addr", 32'(sram_addr), 32'h10000);
      cpu_addr = 16'h0000; #1;
      check("R1 reset low addr", 32'(sram_addr), 32'h00000);
      check("R1 reset ovf", 32'(swap_ovf), 32'd0);

      // R2 R3 R4 R5: sweep sizes, bases, swaps, random addresses
      for (int k = 0; k < 5; k++) begin
         host_write(1'b0, {3'b000, sizes[k]});
         for (int j = 0; j < 4; j++) begin
            bs = (j == 0) ? 5'h00 : (j == 1) ? 5'h1F : 5'($urandom);
            host_write(1'b1, {3'b000, bs});
            for (int q = 0; q < 3; q++) begin
               sw = 8'($urandom_range(0, 223));
               cpu_load(sw);
               probe("R5 window start", {bs, 11'h000});
               probe("R5 window high", {bs, 11'h7FF});
               for (int t = 0; t < 20; t++) probe("R3 R4 random", 16'($urandom));
            end
         end
      end

      // R10 window size per encoding
      for (int k = 0; k < 5; k++) begin
         host_write(1'b0, {3'b000, sizes[k]});
         host_write(1'b1, 8'h15);
         cnt = 0;
         for (int p = 0; p < 32; p++) begin
            cpu_addr = {5'(p), 11'h123}; #1;
            if (banked) cnt++;
         end
         check("R10 window blocks", 32'(cnt), 32'(32 >> $countones(sizes[k])));
      end

      // R6 load and hold
      host_write(1'b0, 8'h1F); host_write(1'b1, 8'h03);
      cpu_load(8'd0);
      cpu_addr = 16'h1800; #1;
      check("R6 load zero plus offset", 32'(sram_addr), 32'h10000);
      cpu_load(8'd223);
      cpu_addr = 16'h1A5A; #1;
      check("R6 load max legal", 32'(sram_addr), 32'({8'hFF, 11'h25A}));
      check("R6 ovf clear", 32'(swap_ovf), 32'd0);
      repeat (4) @(negedge clk);
      #1;
      check("R6 hold", 32'(sram_addr), 32'({8'hFF, 11'h25A}));

      // R7 overflow saturates then clears
      cpu_load(8'd10);
      cpu_load(8'd224);
      #1;
      check("R7 ovf set", 32'(swap_ovf), 32'd1);
      check("R7 saturate", 32'(sram_addr[18:11]), 32'hFF);
      cpu_load(8'd255);
      #1;
      check("R7 saturate 255", 32'(sram_addr[18:11]), 32'hFF);
      cpu_load(8'd5);
      #1;
      check("R7 ovf cleared", 32'(swap_ovf), 32'd0);
      check("R7 swap after clear", 32'(sram_addr[18:11]), 32'd37);

      // R8 upper data bits ignored
      host_write(1'b0, 8'hE8);
      host_write(1'b1, 8'hA2);
      probe("R8 masked write in", 16'h1234);
      cpu_addr = 16'h7777; #1;
      check("R8 mask only low bits", 32'(banked), 32'(in_win(16'h7777, 5'h08, 5'h02)));

      // R9 odd and empty masks
      host_write(1'b0, 8'h05);
      host_write(1'b1, 8'h1F);
      for (int t = 0; t < 30; t++) probe("R9 odd mask", 16'($urandom));
      host_write(1'b0, 8'h00);
      for (int t = 0; t < 10; t++) begin
         cpu_addr = 16'($urandom); #1;
         check("R9 empty mask banked", 32'(banked), 32'd1);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule